// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block holds a programmed burst setting and turns a single start request into the stream of column addresses that one memory burst visits. A configuration strobe captures a 12-bit mode word giving the burst length, the wrap order, the read latency and a flag that forces writes to a single beat. A start strobe carries the first column and says whether the burst is a read or a write. From the next clock on, the block presents one column per accepted beat, with a valid flag and a last-beat flag.

The column stream is a valid/ready output. A beat is consumed only in a cycle where `col_valid` and `col_ready` are both high. While `col_ready` is low the block holds the same column and keeps `col_valid` high. Two inputs override the stream regardless of `col_ready`. `stop` ends the current burst. A new `start` abandons the current burst and begins the new one on the next clock. When both arrive in the same cycle, `start` wins. The settings in force when `start` is sampled apply to the whole burst, so a reprogramming in the middle of a burst does not change it.

Top module: `burst_col_seq`

## Requirements
- R1: Mode word fields. Bits [2:0] set the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. Bit 3 selects the wrap order: 0 is sequential and 1 is interleaved. Bits [6:4] set the latency: 010 gives 2 and 011 gives 3. Bit 9 set to 1 makes every write a single beat. A load takes effect one cycle later, and `cas_latency` shows the latency value (2 after reset).
- R2: A load whose length code or latency code is reserved raises `cfg_error` in the next cycle and leaves every previous setting in force. A load with both codes legal clears `cfg_error`. `cfg_error` is 0 after reset.
- R3: In the cycle after `start`, `col_valid` is 1 and `col_addr` equals the `start_col` that was sampled with it.
- R4: Sequential order. Beat k carries low bits equal to (start low bits + k) modulo BL, where BL is the burst length and the low bits are the bottom log2(BL) bits. For example, BL=4 from column 2 gives 2,3,0,1.
- R5: Interleaved order. Beat k carries low bits equal to (start low bits XOR k). For example, BL=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: Column bits above the low log2(BL) bits keep the start column's value on every beat.
- R7: A full-page burst counts upward over all 8 column bits modulo 256 and ignores the wrap-order bit. It never raises `col_last` and runs until it is stopped or restarted.
- R8: A burst that is not full-page delivers exactly BL accepted beats. `col_last` is high on the final beat, and `col_valid` is low in the cycle after that beat is accepted, unless a new start arrived.
- R9: When bit 9 is 1 and the start is a write, the burst is one beat long, with `col_last` high. Reads still use the programmed length.
- R10: When `col_valid` is 1 and `col_ready` is 0, with no start and no stop, the next cycle shows the same column and `col_valid` stays 1.
- R11: `stop` without `start` makes `col_valid` low in the next cycle. A `stop` while idle has no effect.
- R12: A `start` during a burst shows the new start column in the next cycle, even if `stop` is high in the same cycle.
- R13: A mode load during a burst does not change that burst's length or order. The next start uses the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` this cycle |
| mode_word | input | 12 | Burst setting word |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| start_is_write | input | 1 | The burst being started is a write |
| stop | input | 1 | End the running burst |
| col_ready | input | 1 | Consumer accepts the presented column |
| col_valid | output | 1 | A column is presented |
| col_addr | output | 8 | Column for the current beat |
| col_last | output | 1 | Current beat is the final one of a bounded burst |
| cfg_error | output | 1 | Last mode load carried a reserved code |
| cas_latency | output | 2 | Programmed read latency (2 or 3) |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge. They also assume that `start`, `stop` and `col_ready` are judged only on that edge, so a pulse of any length is read as one request per cycle. They do not assume that `start` waits for the end of the running burst, or that `col_ready` is ever raised. The stimulus drives all inputs on the falling edge, from a fixed-seed `$urandom` stream. That stream mixes legal and reserved mode words, overlapping starts, stray stops and long stretches of low `col_ready`. Directed runs cover the wrap examples, the full-page wrap past column 255, the single-beat write and a mid-burst reprogram.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Field positions inside the mode word; the decode depends on them.
  localparam int unsigned LEN_LSB = 0;
  localparam int unsigned ORD_BIT = 3;
  localparam int unsigned LAT_LSB = 4;
  localparam int unsigned WRS_BIT = 9;
  localparam int unsigned LG_W    = 2;

  localparam logic [2:0] LEN_FULL = 3'b111;
  localparam logic [2:0] LAT_TWO  = 3'b010;
  localparam logic [2:0] LAT_THREE = 3'b011;

  typedef struct packed {
    logic [LG_W-1:0] len_log2;
    logic            full_page;
    logic            interleave;
    logic            lat3;
    logic            wr_single;
  } bcs_mode_t;

  localparam bcs_mode_t MODE_RESET = '{len_log2: '0, full_page: 1'b0,
                                       interleave: 1'b0, lat3: 1'b0,
                                       wr_single: 1'b0};

  function automatic logic len_ok(input logic [2:0] c);
    return (c[2] == 1'b0) || (c == LEN_FULL);
  endfunction

  function automatic logic lat_ok(input logic [2:0] c);
    return (c == LAT_TWO) || (c == LAT_THREE);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int unsigned OP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] word,
  output bcs_mode_t       mode,
  output logic            err
);
  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       accept;
  bcs_mode_t  decoded;
  logic       unused_word;

  assign len_code = word[LEN_LSB +: 3];
  assign lat_code = word[LAT_LSB +: 3];
  assign accept   = len_ok(len_code) && lat_ok(lat_code);
  assign unused_word = ^word;

  always_comb begin
    decoded            = MODE_RESET;
    decoded.full_page  = (len_code == LEN_FULL);
    decoded.len_log2   = decoded.full_page ? '0 : len_code[LG_W-1:0];
    decoded.interleave = word[ORD_BIT];
    decoded.lat3       = (lat_code == LAT_THREE);
    decoded.wr_single  = word[WRS_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
      err  <= 1'b0;
    end else if (load) begin
      err <= !accept;
      if (accept) mode <= decoded;
    end
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_write,
  input  logic             stop,
  input  logic             ready,
  input  logic [LG_W-1:0]  cfg_len_log2,
  input  logic             cfg_full,
  input  logic             cfg_ilv,
  input  logic             cfg_wr_single,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] base,
  output logic [LG_W-1:0]  lg,
  output logic             full,
  output logic             ilv,
  output logic             last
);
  logic             single_wr;
  logic [COL_W-1:0] last_idx;
  logic             fire;

  assign single_wr = start_is_write && cfg_wr_single;
  assign last_idx  = ~({COL_W{1'b1}} << lg);
  assign last      = active && !full && (idx == last_idx);
  assign fire      = active && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      lg     <= '0;
      full   <= 1'b0;
      ilv    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= start_col;
      lg     <= single_wr ? '0 : cfg_len_log2;
      full   <= cfg_full && !single_wr;
      ilv    <= cfg_ilv && !cfg_full && !single_wr;
    end else if (stop && active) begin
      active <= 1'b0;
    end else if (fire) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [LG_W-1:0]  lg,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] span;
  logic [COL_W-1:0] sum;

  assign span = full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << lg);
  assign sum  = base + idx;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!span[i])  col[i] = base[i];
      else if (ilv)  col[i] = base[i] ^ idx[i];
      else           col[i] = sum[i];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned OP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [OP_W-1:0]  mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_write,
  input  logic             stop,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             cfg_error,
  output logic [1:0]       cas_latency
);
  bcs_mode_t        mode;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] base;
  logic [LG_W-1:0]  lg;
  logic             full;
  logic             ilv;

  bcs_mode_reg #(.OP_W(OP_W)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mode_load),
    .word (mode_word),
    .mode (mode),
    .err  (cfg_error)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_col     (start_col),
    .start_is_write(start_is_write),
    .stop          (stop),
    .ready         (col_ready),
    .cfg_len_log2  (mode.len_log2),
    .cfg_full      (mode.full_page),
    .cfg_ilv       (mode.interleave),
    .cfg_wr_single (mode.wr_single),
    .active        (col_valid),
    .idx           (idx),
    .base          (base),
    .lg            (lg),
    .full          (full),
    .ilv           (ilv),
    .last          (col_last)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_gen (
    .base(base),
    .idx (idx),
    .lg  (lg),
    .full(full),
    .ilv (ilv),
    .col (col_addr)
  );

  assign cas_latency = mode.lat3 ? 2'd3 : 2'd2;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned OP_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [OP_W-1:0]  mode_word,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             cfg_error,
  input logic [1:0]       cas_latency
);
  logic word_ok;
  assign word_ok = len_ok(mode_word[LEN_LSB +: 3]) && lat_ok(mode_word[LAT_LSB +: 3]);

  p_lat_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_latency == 2'd2) || (cas_latency == 2'd3));

  p_reserved_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load && !word_ok |=> cfg_error && $stable(cas_latency));

  p_legal_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load && word_ok |=> !cfg_error);

  p_first_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_addr == $past(start_col)));

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && col_last && !start |=> !col_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !start && !stop |=> col_valid && $stable(col_addr));

  p_stop_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !col_valid);

  p_last_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .OP_W(OP_W)) u_chk (.*);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_is_write = 1'b0;
  logic       stop = 1'b0;
  logic       col_ready = 1'b0;
  logic       col_valid;
  logic [7:0] col_addr;
  logic       col_last;
  logic       cfg_error;
  logic [1:0] cas_latency;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_is_write(start_is_write),
    .stop(stop), .col_ready(col_ready), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .cfg_error(cfg_error),
    .cas_latency(cas_latency)
  );

  // Reference state built from the requirements.
  int m_cfg_len = 1;   // beats, 0 means full page
  bit m_cfg_ilv = 0;
  int m_cfg_lat = 2;
  bit m_cfg_ws  = 0;
  bit m_err     = 0;
  bit m_act     = 0;
  int m_idx     = 0;
  int m_base    = 0;
  int m_len     = 1;
  bit m_ilv     = 0;

  function automatic int exp_col(int b, int k, int len, bit il);
    int blk = (len == 0) ? 256 : len;
    int off = b % blk;
    int low = il ? (off ^ k) : ((off + k) % blk);
    return b - off + low;
  endfunction

  function automatic bit exp_last();
    return m_act && (m_len != 0) && (m_idx == m_len - 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8", int'(col_valid), int'(m_act));
    if (m_act) begin
      chk(m_len == 0 ? "R7" : (m_ilv ? "R5" : "R4"), int'(col_addr),
          exp_col(m_base, m_idx, m_len, m_ilv));
      chk("R8", int'(col_last), int'(exp_last()));
    end
    chk("R1", int'(cas_latency), m_cfg_lat);
    chk("R2", int'(cfg_error), int'(m_err));
  endtask

  task automatic cyc(input bit ld, input logic [11:0] w, input bit st,
                     input logic [7:0] sc, input bit wr, input bit sp, input bit rd);
    int lc;
    int tc;
    bit fin;
    compare();
    mode_load = ld; mode_word = w; start = st; start_col = sc;
    start_is_write = wr; stop = sp; col_ready = rd;
    fin = exp_last();
    if (st) begin
      m_act = 1; m_idx = 0; m_base = int'(sc);
      if (wr && m_cfg_ws) begin m_len = 1; m_ilv = 0; end
      else begin m_len = m_cfg_len; m_ilv = (m_cfg_len == 0) ? 1'b0 : m_cfg_ilv; end
    end else if (sp && m_act) begin
      m_act = 0;
    end else if (m_act && rd) begin
      if (fin) m_act = 0;
      else m_idx = (m_idx + 1) % 256;
    end
    if (ld) begin
      lc = int'(w[2:0]); tc = int'(w[6:4]);
      if ((lc <= 3 || lc == 7) && (tc == 2 || tc == 3)) begin
        m_err = 0;
        m_cfg_len = (lc == 7) ? 0 : (1 << lc);
        m_cfg_ilv = w[3]; m_cfg_lat = tc; m_cfg_ws = w[9];
      end else m_err = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rd = 1'b1);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, 0, rd);
  endtask

  task automatic load(input logic [11:0] w);
    cyc(1, w, 0, '0, 0, 0, 1);
  endtask

  task automatic go(input logic [7:0] sc, input bit wr = 1'b0);
    cyc(0, '0, 1, sc, wr, 0, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    chk("R8", int'(col_valid), 0);
    chk("R1", int'(cas_latency), 2);
    chk("R2", int'(cfg_error), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 sequential BL4, latency 3
    load(12'h032);
    chk("R1", int'(cas_latency), 3);
    go(8'h42);
    chk("R3", int'(col_addr), 8'h42);
    idle(1); chk("R4", int'(col_addr), 8'h43);
    idle(1); chk("R4", int'(col_addr), 8'h40);
    idle(1); chk("R4", int'(col_addr), 8'h41); chk("R8", int'(col_last), 1);
    idle(1); chk("R8", int'(col_valid), 0);

    // R5/R6 interleaved BL8
    load(12'h02B);
    go(8'hA5);
    chk("R5", int'(col_addr), 8'hA5);
    idle(1); chk("R5", int'(col_addr), 8'hA4);
    idle(1); chk("R5", int'(col_addr), 8'hA7);
    chk("R6", int'(col_addr[7:3]), 5'h14);
    idle(6);

    // R2 reserved codes
    load(12'h034);
    chk("R2", int'(cfg_error), 1); chk("R2", int'(cas_latency), 2);
    load(12'h002);
    chk("R2", int'(cfg_error), 1);
    load(12'h022);
    chk("R2", int'(cfg_error), 0);

    // R7 full page with order bit set
    load(12'h02F);
    go(8'hFE);
    chk("R7", int'(col_addr), 8'hFE);
    idle(1); chk("R7", int'(col_addr), 8'hFF);
    idle(1); chk("R7", int'(col_addr), 8'h00);
    idle(300);
    chk("R7", int'(col_valid), 1); chk("R7", int'(col_last), 0);
    cyc(0, '0, 0, '0, 0, 1, 1);
    chk("R11", int'(col_valid), 0);
    cyc(0, '0, 0, '0, 0, 1, 1);
    chk("R11", int'(col_valid), 0);

    // R9 single-beat writes
    load(12'h232);
    go(8'h10, 1'b1);
    chk("R9", int'(col_valid), 1); chk("R9", int'(col_last), 1);
    idle(1); chk("R9", int'(col_valid), 0);
    go(8'h10, 1'b0);
    idle(3); chk("R9", int'(col_last), 1); chk("R9", int'(col_addr), 8'h13);
    idle(1);

    // R10 back-pressure
    go(8'h21);
    idle(3, 1'b0); chk("R10", int'(col_addr), 8'h21); chk("R10", int'(col_valid), 1);
    idle(1); chk("R10", int'(col_addr), 8'h22);
    idle(2); chk("R10", int'(col_addr), 8'h20);
    idle(1);

    // R12 restart beats stop
    go(8'h30);
    idle(1);
    cyc(0, '0, 1, 8'h55, 0, 1, 1);
    chk("R12", int'(col_valid), 1); chk("R12", int'(col_addr), 8'h55);
    idle(3); chk("R12", int'(col_addr), 8'h54);
    idle(1);

    // R13 reprogram mid-burst
    go(8'h60);
    load(12'h031);
    idle(2); chk("R13", int'(col_addr), 8'h63); chk("R13", int'(col_last), 1);
    idle(1);
    go(8'h60);
    idle(1); chk("R13", int'(col_addr), 8'h61); chk("R13", int'(col_last), 1);
    idle(1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] lat;
      logic [11:0] w;
      case ($urandom % 4)
        0: lat = 3'd2;
        1: lat = 3'd3;
        default: lat = (($urandom % 3) == 0) ? 3'($urandom) : 3'd2;
      endcase
      w = {2'b00, 1'($urandom), 2'b00, lat, 1'($urandom), 3'($urandom)};
      cyc(($urandom % 16) == 0, w, ($urandom % 8) == 0, 8'($urandom),
          1'($urandom), ($urandom % 20) == 0, ($urandom % 4) != 0);
    end
    compare();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule